// File: doc/BRIEF.md
# Micro-op Unlamination Stage

This stage sits between a queue of decoded micro-ops and the register rename stage. Each incoming entry is one of four things: a simple micro-op, a macro-fused compare-and-branch, a fused load-plus-ALU pair, or a fused store pair (store-address plus store-data). For each fused pair the stage decides whether it can enter rename as one slot or must be split into its two halves. Each entry carries its number of register sources, a flag saying whether it reads the status flags, and a flag for indexed (base plus index) addressing.

The split rule has two modes, chosen per entry by `ext_mode`. In the base mode a pair is split when its input count is above 2, or when it uses indexed addressing. In the extended mode the input limit is 3, and indexed addressing alone does not force a split. The status flags count as one input.

Output slots leave in program order over a valid/ready handshake, one slot per cycle. The two halves of a split pair go out in consecutive slots. The stage also keeps two running counts. The fused-domain count advances by one for each emitted slot. The unfused-domain count advances by one for each micro-op that will reach execution.

Top module: `uop_unlam_stage`

## Requirements
- R1: Input kind encoding is 0 = simple, 1 = load+op pair, 2 = store pair, 3 = macro-fused compare-and-branch. A simple entry leaves as out_code 0 and a compare-and-branch entry leaves as out_code 1. Both take one slot, carry their tag unchanged, and are never split, whatever their source count or address flag.
- R2: A pair's input count is in_nsrc plus one when in_rd_flags is 1.
- R3: In base mode (ext_mode = 0), a pair whose input count exceeds 2 is split.
- R4: In extended mode (ext_mode = 1), a pair whose input count exceeds 3 is split, and a pair with 3 or fewer inputs stays fused.
- R5: In base mode, a pair with in_indexed = 1 is always split. In extended mode, indexed addressing alone does not cause a split.
- R6: A split load+op pair leaves as out_code 4 (load) and then out_code 5 (operation). A split store pair leaves as out_code 6 (store-address) and then out_code 7 (store-data). Both halves carry the entry's tag.
- R7: A pair kept fused leaves as a single slot: out_code 2 for load+op, out_code 3 for a store pair.
- R8: fused_cnt increases by exactly one for each output handshake and holds otherwise.
- R9: unfused_cnt increases by 2 for a fused pair slot and by 1 for any other slot, and holds when there is no handshake.
- R10: While the second half of a split pair is still waiting, in_ready is 0. With out_ready held at 1, the two halves leave in consecutive cycles.
- R11: While out_valid is 1 and out_ready is 0, out_valid, out_code and out_tag hold their values.
- R12: Synchronous reset clears out_valid, any waiting half and both counters.
- R13: A memory read-modify-write with a simple address arrives as a load+op pair and a store pair, each with at most 2 inputs. In base mode it yields 2 slots and adds 4 to unfused_cnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode | input | 1 | 0 = base split rule, 1 = extended rule |
| in_valid | input | 1 | Input entry valid |
| in_ready | output | 1 | Stage accepts the input entry |
| in_kind | input | 2 | Entry kind (R1 encoding) |
| in_nsrc | input | SRC_W (3) | Register source count |
| in_rd_flags | input | 1 | Entry reads status flags |
| in_indexed | input | 1 | Entry uses base-plus-index addressing |
| in_tag | input | TAG_W (8) | Payload carried to every emitted slot |
| out_valid | output | 1 | Output slot valid |
| out_ready | input | 1 | Rename accepts the slot |
| out_code | output | 3 | Emitted micro-op code (R1, R6, R7) |
| out_tag | output | TAG_W (8) | Tag of the emitted slot |
| fused_cnt | output | CNT_W (16) | Fused-domain slot count |
| unfused_cnt | output | CNT_W (16) | Unfused-domain micro-op count |

## Verification
Two functions can fall on the same clock edge: the first half of a split pair leaving the stage, and a new entry offered at the input. In that cycle the stage must hold in_ready low so the waiting second half goes out first. The bench provokes this by stalling the output with a split pair inside, then raising out_ready while a new entry is already waiting. It judges the result by the sampled in_ready and by the cycle stamps of the emitted slots, which must show load, operation and the new entry on three consecutive cycles.

// File: rtl/uop_unlam_pkg.sv
package uop_unlam_pkg;

   typedef enum logic [1:0] {
      IN_SINGLE = 2'd0,
      IN_LDOP   = 2'd1,
      IN_STPAIR = 2'd2,
      IN_CMPBR  = 2'd3
   } in_kind_e;

   typedef enum logic [2:0] {
      OC_SINGLE = 3'd0,
      OC_CMPBR  = 3'd1,
      OC_LDOP   = 3'd2,
      OC_STPAIR = 3'd3,
      OC_LOAD   = 3'd4,
      OC_ALUOP  = 3'd5,
      OC_STA    = 3'd6,
      OC_STD    = 3'd7
   } out_code_e;

   function automatic logic code_is_fused(input logic [2:0] c);
      return (c == OC_LDOP) || (c == OC_STPAIR);
   endfunction

endpackage

// File: rtl/uop_split_decide.sv
module uop_split_decide
   import uop_unlam_pkg::*;
#(
   parameter int SRC_W            = 3,
   parameter int BASE_LIMIT       = 2,
   parameter int EXT_LIMIT        = 3,
   parameter bit BASE_INDEX_SPLIT = 1'b1
) (
   input  logic [1:0]       kind,
   input  logic [SRC_W-1:0] nsrc,
   input  logic             rd_flags,
   input  logic             indexed,
   input  logic             ext_mode,
   output logic             split,
   output logic [2:0]       first_code,
   output logic [2:0]       second_code
);
   localparam int CW = SRC_W + 1;
   localparam logic [CW-1:0] BASE_L = CW'(BASE_LIMIT);
   localparam logic [CW-1:0] EXT_L  = CW'(EXT_LIMIT);

   logic [CW-1:0] n_inputs;
   logic [CW-1:0] limit;
   logic          over_limit;
   logic          idx_force;

   generate
      if (BASE_INDEX_SPLIT) begin : g_idx_rule
         assign idx_force = indexed && !ext_mode;
      end else begin : g_no_idx_rule
         assign idx_force = 1'b0;
      end
   endgenerate

   always_comb begin
      n_inputs   = {1'b0, nsrc} + CW'(rd_flags);
      limit      = ext_mode ? EXT_L : BASE_L;
      over_limit = n_inputs > limit;
      split       = 1'b0;
      first_code  = OC_SINGLE;
      second_code = OC_SINGLE;
      case (kind)
         IN_LDOP: begin
            split       = over_limit || idx_force;
            first_code  = split ? OC_LOAD : OC_LDOP;
            second_code = OC_ALUOP;
         end
         IN_STPAIR: begin
            split       = over_limit || idx_force;
            first_code  = split ? OC_STA : OC_STPAIR;
            second_code = OC_STD;
         end
         IN_CMPBR: first_code = OC_CMPBR;
         default:  first_code = OC_SINGLE;
      endcase
   end
endmodule

// File: rtl/uop_slot_reg.sv
module uop_slot_reg #(
   parameter int TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             take,
   input  logic             split,
   input  logic [2:0]       first_code,
   input  logic [2:0]       second_code,
   input  logic [TAG_W-1:0] tag_in,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [2:0]       out_code,
   output logic [TAG_W-1:0] out_tag,
   output logic             pend
);
   logic [2:0] pend_code;
   logic       fire;

   assign fire = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_code  <= '0;
         out_tag   <= '0;
         pend      <= 1'b0;
         pend_code <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         out_code  <= first_code;
         out_tag   <= tag_in;
         pend      <= split;
         pend_code <= second_code;
      end else if (fire && pend) begin
         out_code  <= pend_code;
         pend      <= 1'b0;
      end else if (fire) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/uop_domain_counters.sv
module uop_domain_counters
   import uop_unlam_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fire,
   input  logic [2:0]       code,
   output logic [CNT_W-1:0] fused_cnt,
   output logic [CNT_W-1:0] unfused_cnt
);
   logic [CNT_W-1:0] unf_step;

   assign unf_step = code_is_fused(code) ? CNT_W'(2) : CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         fused_cnt   <= '0;
         unfused_cnt <= '0;
      end else if (fire) begin
         fused_cnt   <= fused_cnt + CNT_W'(1);
         unfused_cnt <= unfused_cnt + unf_step;
      end
   end
endmodule

// File: rtl/uop_unlam_stage.sv
module uop_unlam_stage #(
   parameter int TAG_W            = 8,
   parameter int SRC_W            = 3,
   parameter int CNT_W            = 16,
   parameter int BASE_LIMIT       = 2,
   parameter int EXT_LIMIT        = 3,
   parameter bit BASE_INDEX_SPLIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ext_mode,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [1:0]       in_kind,
   input  logic [SRC_W-1:0] in_nsrc,
   input  logic             in_rd_flags,
   input  logic             in_indexed,
   input  logic [TAG_W-1:0] in_tag,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [2:0]       out_code,
   output logic [TAG_W-1:0] out_tag,
   output logic [CNT_W-1:0] fused_cnt,
   output logic [CNT_W-1:0] unfused_cnt
);
   initial begin
      if (TAG_W < 1)              $error("TAG_W must be at least 1");
      if (SRC_W < 2)              $error("SRC_W must be at least 2");
      if (CNT_W < 2)              $error("CNT_W must be at least 2");
      if (EXT_LIMIT < BASE_LIMIT) $error("EXT_LIMIT below BASE_LIMIT");
      if (EXT_LIMIT >= (1 << (SRC_W + 1))) $error("EXT_LIMIT too wide");
   end

   logic       split;
   logic [2:0] first_code;
   logic [2:0] second_code;
   logic       pend;
   logic       take;

   assign in_ready = !pend && (!out_valid || out_ready);
   assign take     = in_valid && in_ready;

   uop_split_decide #(
      .SRC_W(SRC_W), .BASE_LIMIT(BASE_LIMIT),
      .EXT_LIMIT(EXT_LIMIT), .BASE_INDEX_SPLIT(BASE_INDEX_SPLIT)
   ) u_decide (
      .kind(in_kind), .nsrc(in_nsrc), .rd_flags(in_rd_flags),
      .indexed(in_indexed), .ext_mode(ext_mode),
      .split(split), .first_code(first_code), .second_code(second_code)
   );

   uop_slot_reg #(.TAG_W(TAG_W)) u_slot (
      .clk(clk), .rst(rst), .take(take), .split(split),
      .first_code(first_code), .second_code(second_code),
      .tag_in(in_tag), .out_ready(out_ready),
      .out_valid(out_valid), .out_code(out_code), .out_tag(out_tag),
      .pend(pend)
   );

   uop_domain_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .fire(out_valid && out_ready), .code(out_code),
      .fused_cnt(fused_cnt), .unfused_cnt(unfused_cnt)
   );
endmodule

// File: rtl/uop_unlam_stage_chk.sv
module uop_unlam_stage_chk #(
   parameter int TAG_W = 8,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [2:0]       out_code,
   input logic [TAG_W-1:0] out_tag,
   input logic [CNT_W-1:0] fused_cnt,
   input logic [CNT_W-1:0] unfused_cnt
);
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_tag))); // R11

   AST_LOAD_BEFORE_OP: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && out_code == 3'd4) |=> (out_valid && out_code == 3'd5)); // R6

   AST_STA_BEFORE_STD: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && out_code == 3'd6) |=> (out_valid && out_code == 3'd7)); // R6

   AST_HALF_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
      (out_valid && (out_code == 3'd4 || out_code == 3'd6)) |-> !in_ready); // R10

   AST_FUSED_STEP: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready) |=> (fused_cnt == $past(fused_cnt) + CNT_W'(1))); // R8

   AST_FUSED_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(out_valid && out_ready) |=> $stable(fused_cnt)); // R8

   AST_UNFUSED_STEP: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready) |=> (unfused_cnt == $past(unfused_cnt) +
         (($past(out_code) == 3'd2 || $past(out_code) == 3'd3) ? CNT_W'(2) : CNT_W'(1)))); // R9

   AST_UNFUSED_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(out_valid && out_ready) |=> $stable(unfused_cnt)); // R9

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!out_valid && fused_cnt == '0 && unfused_cnt == '0)); // R12
endmodule

bind uop_unlam_stage uop_unlam_stage_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
   .out_ready(out_ready), .out_code(out_code), .out_tag(out_tag),
   .fused_cnt(fused_cnt), .unfused_cnt(unfused_cnt)
);

// File: tb/uop_unlam_stage_tb.sv
module uop_unlam_stage_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ext_mode = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_kind = '0;
   logic [2:0]  in_nsrc = '0;
   logic        in_rd_flags = 1'b0;
   logic        in_indexed = 1'b0;
   logic [7:0]  in_tag = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [2:0]  out_code;
   logic [7:0]  out_tag;
   logic [15:0] fused_cnt;
   logic [15:0] unfused_cnt;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int log_n  = 0;
   logic [2:0] code_log [0:127];
   logic [7:0] tag_log  [0:127];
   int         cyc_log  [0:127];

   always #(CLK_PERIOD/2) clk = ~clk;

   uop_unlam_stage u_dut (
      .clk(clk), .rst(rst), .ext_mode(ext_mode),
      .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
      .in_nsrc(in_nsrc), .in_rd_flags(in_rd_flags), .in_indexed(in_indexed),
      .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
      .out_code(out_code), .out_tag(out_tag),
      .fused_cnt(fused_cnt), .unfused_cnt(unfused_cnt)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!rst && out_valid && out_ready && log_n < 128) begin
         code_log[log_n] = out_code;
         tag_log[log_n]  = out_tag;
         cyc_log[log_n]  = cyc;
         log_n = log_n + 1;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] k, input logic [2:0] ns, input logic fl,
                       input logic idx, input logic [7:0] tg);
      in_kind = k; in_nsrc = ns; in_rd_flags = fl; in_indexed = idx; in_tag = tg;
      in_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (!out_valid && in_ready) break;
      end
      @(posedge clk); #1;
   endtask

   task automatic expect_slot(input int idx, input logic [2:0] c, input logic [7:0] tg,
                              input string req);
      chk(idx < log_n, req, log_n, idx + 1);
      chk(code_log[idx] == c, req, code_log[idx], c);
      chk(tag_log[idx] == tg, req, tag_log[idx], tg);
   endtask

   task automatic expect_deltas(input logic [15:0] f0, input logic [15:0] u0,
                                input int df, input int du, input string req);
      chk(fused_cnt == f0 + 16'(df), req, int'(fused_cnt - f0), df);
      chk(unfused_cnt == u0 + 16'(du), req, int'(unfused_cnt - u0), du);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!out_valid, "R12 out_valid after reset", out_valid, 0);
      chk(in_ready, "R12 in_ready after reset", in_ready, 1);
      chk(fused_cnt == 0 && unfused_cnt == 0, "R12 counters after reset",
          fused_cnt + unfused_cnt, 0);
      @(posedge clk); #1;
   endtask

   task automatic t_rmw();
      int s = log_n;
      logic [15:0] f0 = fused_cnt, u0 = unfused_cnt;
      ext_mode = 1'b0;
      send(2'd1, 3'd1, 1'b0, 1'b0, 8'h10);
      send(2'd2, 3'd2, 1'b0, 1'b0, 8'h11);
      drain();
      expect_slot(s,     3'd2, 8'h10, "R7 R13 load+op kept fused");
      expect_slot(s + 1, 3'd3, 8'h11, "R7 R13 store pair kept fused");
      chk(log_n == s + 2, "R13 slot count", log_n - s, 2);
      expect_deltas(f0, u0, 2, 4, "R13 R8 R9 rmw accounting");
   endtask

   task automatic t_flags_base();
      int s = log_n;
      logic [15:0] f0 = fused_cnt, u0 = unfused_cnt;
      ext_mode = 1'b0;
      send(2'd1, 3'd2, 1'b0, 1'b0, 8'h20);
      send(2'd1, 3'd2, 1'b1, 1'b0, 8'h21);
      drain();
      expect_slot(s,     3'd2, 8'h20, "R3 two inputs stay fused");
      expect_slot(s + 1, 3'd4, 8'h21, "R2 R3 flags make three, load first");
      expect_slot(s + 2, 3'd5, 8'h21, "R6 operation second");
      expect_deltas(f0, u0, 3, 4, "R9 mixed accounting");
   endtask

   task automatic t_index_base();
      int s = log_n;
      logic [15:0] f0 = fused_cnt, u0 = unfused_cnt;
      ext_mode = 1'b0;
      send(2'd1, 3'd1, 1'b0, 1'b1, 8'h30);
      send(2'd2, 3'd1, 1'b0, 1'b1, 8'h31);
      drain();
      expect_slot(s,     3'd4, 8'h30, "R5 indexed load+op split");
      expect_slot(s + 1, 3'd5, 8'h30, "R6 split op half");
      expect_slot(s + 2, 3'd6, 8'h31, "R5 R6 indexed store split, address first");
      expect_slot(s + 3, 3'd7, 8'h31, "R6 store data second");
      expect_deltas(f0, u0, 4, 4, "R8 R9 split accounting");
   endtask

   task automatic t_ext();
      int s = log_n;
      logic [15:0] f0 = fused_cnt, u0 = unfused_cnt;
      ext_mode = 1'b1;
      send(2'd1, 3'd2, 1'b1, 1'b0, 8'h40);
      send(2'd2, 3'd2, 1'b0, 1'b1, 8'h41);
      send(2'd1, 3'd3, 1'b1, 1'b0, 8'h42);
      drain();
      ext_mode = 1'b0;
      expect_slot(s,     3'd2, 8'h40, "R4 three inputs stay fused");
      expect_slot(s + 1, 3'd3, 8'h41, "R5 indexed not split in extended mode");
      expect_slot(s + 2, 3'd4, 8'h42, "R4 four inputs split");
      expect_slot(s + 3, 3'd5, 8'h42, "R6 extended split op half");
      expect_deltas(f0, u0, 4, 6, "R8 R9 extended accounting");
   endtask

   task automatic t_single();
      int s = log_n;
      logic [15:0] f0 = fused_cnt, u0 = unfused_cnt;
      ext_mode = 1'b0;
      send(2'd0, 3'd3, 1'b1, 1'b1, 8'h50);
      send(2'd3, 3'd2, 1'b1, 1'b0, 8'h51);
      drain();
      expect_slot(s,     3'd0, 8'h50, "R1 simple passes unsplit");
      expect_slot(s + 1, 3'd1, 8'h51, "R1 compare-and-branch passes unsplit");
      chk(log_n == s + 2, "R1 one slot each", log_n - s, 2);
      expect_deltas(f0, u0, 2, 2, "R9 singles count one");
   endtask

   task automatic t_stall();
      int s = log_n;
      logic [15:0] f0;
      ext_mode = 1'b0;
      out_ready = 1'b0;
      send(2'd1, 3'd1, 1'b0, 1'b1, 8'h60);
      f0 = fused_cnt;
      @(negedge clk);
      chk(out_valid && out_code == 3'd4 && out_tag == 8'h60, "R11 first half shown",
          out_code, 4);
      chk(!in_ready, "R10 input blocked with half waiting", in_ready, 0);
      repeat (3) @(negedge clk);
      chk(out_valid && out_code == 3'd4 && out_tag == 8'h60, "R11 held under stall",
          out_code, 4);
      chk(fused_cnt == f0, "R8 no count under stall", fused_cnt, f0);
      @(posedge clk); #1;
      out_ready = 1'b1;
      in_kind = 2'd0; in_nsrc = 3'd1; in_rd_flags = 1'b0; in_indexed = 1'b0;
      in_tag = 8'h61; in_valid = 1'b1;
      @(negedge clk);
      chk(!in_ready, "R10 new entry waits while load leaves", in_ready, 0);
      forever begin
         if (in_ready) break;
         @(negedge clk);
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      drain();
      expect_slot(s,     3'd4, 8'h60, "R10 load leaves first");
      expect_slot(s + 1, 3'd5, 8'h60, "R10 op follows");
      expect_slot(s + 2, 3'd0, 8'h61, "R10 new entry after pair");
      chk(cyc_log[s + 1] == cyc_log[s] + 1, "R10 halves consecutive",
          cyc_log[s + 1] - cyc_log[s], 1);
      chk(cyc_log[s + 2] == cyc_log[s + 1] + 1, "R10 next entry without bubble",
          cyc_log[s + 2] - cyc_log[s + 1], 1);
   endtask

   task automatic t_reset_mid();
      out_ready = 1'b0;
      send(2'd2, 3'd3, 1'b0, 1'b0, 8'h70);
      rst = 1'b1;
      @(posedge clk); #1;
      rst = 1'b0;
      @(negedge clk);
      chk(!out_valid, "R12 reset drops slot", out_valid, 0);
      chk(in_ready, "R12 reset drops waiting half", in_ready, 1);
      chk(fused_cnt == 0 && unfused_cnt == 0, "R12 reset clears counts",
          fused_cnt + unfused_cnt, 0);
      out_ready = 1'b1;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      t_reset();
      t_rmw();
      t_flags_base();
      t_index_base();
      t_ext();
      t_single();
      t_stall();
      t_reset_mid();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule